// File: doc/BRIEF.md
# Wide Unsigned Multiply/Divide Unit

This block computes unsigned 64-bit multiplication and unsigned 128-by-64 division over many cycles, one result bit per cycle. A multiply returns the full 128-bit product split into two words: the low word for the destination register and the high word for the high-product special register. A divide takes its dividend from two places. The upper word is the value held in the dividend-extension special register, fed in on `hi_in_i`. The lower word is the first operand. The unit returns the quotient and the remainder, and the remainder is meant for the remainder special register.

A caller raises `start_i` for one cycle while `busy_o` is low. The unit then stays busy for a fixed number of cycles, pulses `done_o` once and holds both result words until the next operation finishes. Two divide cases give no real quotient: a zero divisor and a quotient that cannot fit in 64 bits. In both, the unit returns the dividend's upper word as the quotient and its lower word as the remainder. Only the zero-divisor case raises the exception flag, which the arithmetic status register records.

Top module: `wide_muldiv`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `dz_flag_o` are 0 and `result_o` and `aux_o` are all zeros.
- R2: With `op_div_i`=0 (multiply), at `done_o` the value {`aux_o`,`result_o`} equals `opnd_a_i`×`opnd_b_i` as a 128-bit unsigned product, with the high word in `aux_o`.
- R3: With `op_div_i`=1 (divide), `opnd_b_i`≠0 and `hi_in_i`<`opnd_b_i`, at `done_o` the output `result_o` is the quotient and `aux_o` is the remainder of {`hi_in_i`,`opnd_a_i`}÷`opnd_b_i`, and `dz_flag_o` is 0.
- R4: A divide with `opnd_b_i`=0 returns `result_o`=`hi_in_i` and `aux_o`=`opnd_a_i`, and `dz_flag_o` is 1 in the `done_o` cycle.
- R5: A divide with `opnd_b_i`≠0 and `hi_in_i`≥`opnd_b_i` returns `result_o`=`hi_in_i` and `aux_o`=`opnd_a_i`, with `dz_flag_o` 0.
- R6: A start taken at a clock edge makes `busy_o` high for exactly 64 cycles. `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls.
- R7: `start_i` is ignored while `busy_o` is high. Operands, `hi_in_i` and `op_div_i` are captured at the accepted start, so later changes on them do not affect the result.
- R8: `result_o` and `aux_o` change only in a `done_o` cycle and hold their value otherwise. `dz_flag_o` is never high outside a `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation when not busy |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| opnd_a_i | input | 64 | Multiplicand, or low word of the dividend |
| opnd_b_i | input | 64 | Multiplier, or divisor |
| hi_in_i | input | 64 | High word of the dividend (dividend-extension register) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Product low word or quotient |
| aux_o | output | 64 | Product high word or remainder |
| dz_flag_o | output | 1 | Divide-by-zero exception, valid with done_o |

## Verification
A wrong partial product or partial remainder inside the iteration stays hidden until `done_o`. It then appears as a wrong result word, so every operation's outputs are compared in the done cycle. A miscounted step counter shows up within one operation as a busy window of the wrong length or a misplaced done pulse. The bench catches it because it compares busy and done against its own model on every clock. A wrongly latched special case or a wrong flag shows up in the first zero-divisor or overflow divide.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } md_op_e;
endpackage

// File: rtl/md_mul_step.sv
// One shift-add step: conditionally add multiplicand to upper word, shift pair right.
module md_mul_step #(
   parameter int W = 64
) (
   input  logic [W-1:0] hi_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] mcand_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);
   logic [W:0] sum;

   always_comb begin
      sum  = lo_i[0] ? ({1'b0, hi_i} + {1'b0, mcand_i}) : {1'b0, hi_i};
      hi_o = sum[W:1];
      lo_o = {sum[0], lo_i[W-1:1]};
   end
endmodule

// File: rtl/md_div_step.sv
// One restoring step: shift remainder/quotient pair left, subtract divisor when it fits.
module md_div_step #(
   parameter int W = 64
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] quo_i,
   input  logic [W-1:0] dvsr_i,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] quo_o
);
   logic [W:0] shifted;
   logic [W:0] diff;
   logic       fits;

   always_comb begin
      shifted = {rem_i, quo_i[W-1]};
      diff    = shifted - {1'b0, dvsr_i};
      fits    = (shifted >= {1'b0, dvsr_i});
      rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_o   = {quo_i[W-2:0], fits};
   end
endmodule

// File: rtl/md_step_ctr.sv
// Fixed-length run controller: busy for STEPS cycles after a load.
module md_step_ctr #(
   parameter int STEPS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o,
   output logic last_o
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == LAST_CNT) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign last_o = busy_q && (cnt_q == LAST_CNT);
endmodule

// File: rtl/wide_muldiv.sv
module wide_muldiv
   import muldiv_pkg::*;
#(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         op_div_i,
   input  logic [W-1:0] opnd_a_i,
   input  logic [W-1:0] opnd_b_i,
   input  logic [W-1:0] hi_in_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] result_o,
   output logic [W-1:0] aux_o,
   output logic         dz_flag_o
);
   localparam int STEPS = W;

   if (W < 2) begin : g_bad_width
      $error("wide_muldiv: W must be at least 2");
   end

   logic         busy, last, accept;
   md_op_e       op_q;
   logic [W-1:0] hi_q, lo_q, dvsr_q;
   logic         spec_q, dz_q;
   logic [W-1:0] mul_hi_n, mul_lo_n, div_hi_n, div_lo_n;
   logic [W-1:0] hi_n, lo_n;
   logic [W-1:0] res_q, aux_q;
   logic         done_q, dzf_q;

   assign accept = start_i && !busy;

   md_step_ctr #(.STEPS(STEPS)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i),
      .busy_o (busy),
      .last_o (last)
   );

   md_mul_step #(.W(W)) u_mul (
      .hi_i    (hi_q),
      .lo_i    (lo_q),
      .mcand_i (dvsr_q),
      .hi_o    (mul_hi_n),
      .lo_o    (mul_lo_n)
   );

   md_div_step #(.W(W)) u_div (
      .rem_i  (hi_q),
      .quo_i  (lo_q),
      .dvsr_i (dvsr_q),
      .rem_o  (div_hi_n),
      .quo_o  (div_lo_n)
   );

   always_comb begin
      if (op_q == OP_DIV) begin
         hi_n = div_hi_n;
         lo_n = div_lo_n;
      end else begin
         hi_n = mul_hi_n;
         lo_n = mul_lo_n;
      end
   end

   // Working pair: {hi_q,lo_q} is accumulator:multiplier or remainder:quotient.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_MUL;
         hi_q   <= '0;
         lo_q   <= '0;
         dvsr_q <= '0;
         spec_q <= 1'b0;
         dz_q   <= 1'b0;
      end else if (accept) begin
         op_q   <= md_op_e'(op_div_i);
         dvsr_q <= opnd_b_i;
         lo_q   <= opnd_a_i;
         if (op_div_i) begin
            hi_q   <= hi_in_i;
            dz_q   <= (opnd_b_i == '0);
            spec_q <= (opnd_b_i == '0) || (hi_in_i >= opnd_b_i);
         end else begin
            hi_q   <= '0;
            dz_q   <= 1'b0;
            spec_q <= 1'b0;
         end
      end else if (busy && !spec_q) begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end

   // Result registers: loaded on the final step only, held otherwise.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         aux_q  <= '0;
         done_q <= 1'b0;
         dzf_q  <= 1'b0;
      end else begin
         done_q <= last;
         dzf_q  <= last && dz_q;
         if (last) begin
            res_q <= spec_q ? hi_q : lo_n;
            aux_q <= spec_q ? lo_q : hi_n;
         end
      end
   end

   assign busy_o    = busy;
   assign done_o    = done_q;
   assign result_o  = res_q;
   assign aux_o     = aux_q;
   assign dz_flag_o = dzf_q;
endmodule

// File: rtl/wide_muldiv_chk.sv
module wide_muldiv_chk #(
   parameter int W = 64
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         op_div_i,
   input logic [W-1:0] opnd_a_i,
   input logic [W-1:0] opnd_b_i,
   input logic [W-1:0] hi_in_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] result_o,
   input logic [W-1:0] aux_o,
   input logic         dz_flag_o
);
   logic [15:0]    run_len;
   logic           c_op;
   logic [W-1:0]   c_a, c_b, c_hi;
   logic [2*W-1:0] c_prod, c_dvd, c_back;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         c_op    <= 1'b0;
         c_a     <= '0;
         c_b     <= '0;
         c_hi    <= '0;
      end else begin
         run_len <= busy_o ? run_len + 16'd1 : 16'd0;
         if (start_i && !busy_o) begin
            c_op <= op_div_i;
            c_a  <= opnd_a_i;
            c_b  <= opnd_b_i;
            c_hi <= hi_in_i;
         end
      end
   end

   always_comb begin
      c_prod = {{W{1'b0}}, c_a} * {{W{1'b0}}, c_b};
      c_dvd  = {c_hi, c_a};
      c_back = {{W{1'b0}}, result_o} * {{W{1'b0}}, c_b} + {{W{1'b0}}, aux_o};
   end

   initial begin
      assert (!rst_n || !done_o) else $error("done high before reset");
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!busy_o && !done_o && !dz_flag_o && result_o == '0 && aux_o == '0));

   p_mul_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !c_op) |-> ({aux_o, result_o} == c_prod));

   p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && c_op && c_b != '0 && c_hi < c_b) |-> (c_back == c_dvd && aux_o < c_b && !dz_flag_o));

   p_div_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && c_op && c_b == '0) |-> (dz_flag_o && result_o == c_hi && aux_o == c_a));

   p_div_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && c_op && c_b != '0 && c_hi >= c_b) |-> (!dz_flag_o && result_o == c_hi && aux_o == c_a));

   p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_len == 16'(W)));

   p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && run_len < 16'(W - 1)) |=> busy_o);

   p_hold_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(aux_o)));

   p_flag_in_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dz_flag_o |-> done_o);
endmodule

bind wide_muldiv wide_muldiv_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .op_div_i  (op_div_i),
   .opnd_a_i  (opnd_a_i),
   .opnd_b_i  (opnd_b_i),
   .hi_in_i   (hi_in_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .result_o  (result_o),
   .aux_o     (aux_o),
   .dz_flag_o (dz_flag_o)
);

// File: tb/wide_muldiv_bench.sv
module wide_muldiv_bench;
   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         op_div = 1'b0;
   logic [W-1:0] opa = '0, opb = '0, hi_in = '0;
   logic         busy, done, dz;
   logic [W-1:0] res, aux;

   int n_chk = 0;
   int n_fail = 0;
   logic halt = 1'b0;

   always #2 clk = ~clk;

   wide_muldiv #(.W(W)) u_wide_muldiv (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .op_div_i  (op_div),
      .opnd_a_i  (opa),
      .opnd_b_i  (opb),
      .hi_in_i   (hi_in),
      .busy_o    (busy),
      .done_o    (done),
      .result_o  (res),
      .aux_o     (aux),
      .dz_flag_o (dz)
   );

   // Behavioural reference model
   logic         m_busy, m_done, m_dz, m_op;
   int           m_left;
   logic [W-1:0] m_res, m_aux, m_a, m_b, m_hi;

   function automatic logic [2*W:0] ref_calc(input logic op, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic [W-1:0] h);
      logic [2*W-1:0] p, q, r;
      if (!op) begin
         p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
         return {1'b0, p};
      end
      if (b == '0) return {1'b1, a, h};
      if (h >= b) return {1'b0, a, h};
      q = {h, a} / {{W{1'b0}}, b};
      r = {h, a} % {{W{1'b0}}, b};
      return {1'b0, r[W-1:0], q[W-1:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_dz <= 1'b0; m_left <= 0;
         m_res <= '0; m_aux <= '0; m_op <= 1'b0;
         m_a <= '0; m_b <= '0; m_hi <= '0;
      end else begin
         m_done <= 1'b0;
         m_dz   <= 1'b0;
         if (start && !m_busy) begin
            m_busy <= 1'b1; m_left <= W;
            m_op <= op_div; m_a <= opa; m_b <= opb; m_hi <= hi_in;
         end else if (m_busy) begin
            m_left <= m_left - 1;
            if (m_left == 1) begin
               logic [2*W:0] rr;
               rr = ref_calc(m_op, m_a, m_b, m_hi);
               m_busy <= 1'b0;
               m_done <= 1'b1;
               m_dz   <= rr[2*W];
               m_aux  <= rr[2*W-1:W];
               m_res  <= rr[W-1:0];
            end
         end
      end
   end

   task automatic check_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !halt) begin
         check_val("R6 busy", W'(busy), W'(m_busy));
         check_val("R6 done", W'(done), W'(m_done));
         check_val("R8 dz_flag", W'(dz), W'(m_dz));
         check_val("R8 result hold", res, m_res);
         check_val("R8 aux hold", aux, m_aux);
      end
   end

   function automatic logic [W-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic run_op(input logic op, input logic [W-1:0] h, input logic [W-1:0] a,
                         input logic [W-1:0] b, input bit poke);
      string tag;
      logic [2*W:0] e;
      if (!op) tag = "R2 multiply";
      else if (b == '0) tag = "R4 div by zero";
      else if (h >= b) tag = "R5 quotient overflow";
      else tag = "R3 divide";
      if (poke) tag = {tag, " R7 ignored start"};
      e = ref_calc(op, a, b, h);
      @(negedge clk);
      start = 1'b1; op_div = op; hi_in = h; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0; opa = rnd64(); opb = rnd64(); hi_in = rnd64(); op_div = ~op;
      if (poke) begin
         repeat (5) @(negedge clk);
         start = 1'b1; opb = '0;
         @(negedge clk);
         start = 1'b0;
         repeat (52) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int i = 0; i < 80 && !done; i++) @(negedge clk);
      check_val({tag, " done seen"}, W'(done), W'(1));
      check_val({tag, " result"}, res, e[W-1:0]);
      check_val({tag, " aux"}, aux, e[2*W-1:W]);
      check_val({tag, " flag"}, W'(dz), W'(e[2*W]));
   endtask

   task automatic finish_run();
      halt = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_val("R1 busy", W'(busy), '0);
      check_val("R1 done", W'(done), '0);
      check_val("R1 dz", W'(dz), '0);
      check_val("R1 result", res, '0);
      check_val("R1 aux", aux, '0);

      run_op(1'b0, '0, 64'd7, 64'd9, 1'b0);
      run_op(1'b0, '0, '1, '1, 1'b0);
      run_op(1'b0, '0, '0, 64'h1234_5678_9abc_def0, 1'b0);
      run_op(1'b1, '0, 64'd100, 64'd7, 1'b0);
      run_op(1'b1, 64'h0000_0000_0000_0004, 64'h8000_0000_0000_0001, 64'd5, 1'b0);
      run_op(1'b1, 64'hffff_ffff_ffff_fffe, '1, '1, 1'b0);
      run_op(1'b1, 64'h55, 64'h66, '0, 1'b0);
      run_op(1'b1, 64'h10, 64'h77, 64'h10, 1'b0);
      run_op(1'b1, '1, 64'h3, 64'h2, 1'b0);
      run_op(1'b0, '0, 64'hdead_beef_0000_0001, 64'hffff_0000_ffff_0000, 1'b1);
      run_op(1'b1, 64'h1, 64'h2, 64'h3, 1'b1);
      for (int k = 0; k < 40; k++) begin
         logic [W-1:0] b, h;
         b = rnd64();
         h = (k % 3 == 0) ? rnd64() : (b >> 1);
         if (k % 11 == 5) b = '0;
         run_op(k[0], h, rnd64(), b, 1'b0);
      end
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule